// File: doc/BRIEF.md
# Multi-mode quadrature encoder counter

This block counts motion reported by an incremental encoder's two phase signals, or, in its plain mode, counts clock cycles. Both phase inputs arrive asynchronously and pass through a two-stage synchroniser. An edge detector then feeds a decoder, which turns each qualifying edge into a single up or down step. The step moves a count register that stays between zero and a programmable ceiling, wrapping at either end.

Control arrives as single-cycle write strobes: a staged mode select, an enable bit, a ceiling value and a count preset. The count, the direction of the last step, the enable bit, the active mode and the ceiling all come out on registered outputs. A new mode is written first into a staging register. It becomes active only when the update strobe is pulsed. Counting pauses for that one cycle, and the enable setting is left as it was.

Top module: `quad_enc_counter`

## Requirements
- R1: After synchronous reset the count is 0, the direction flag is 0, enable is 0, the active and staged modes are 00 and the ceiling equals the parameter MAX_CEIL.
- R2: In mode 00 (internal clock), while enabled, the count rises by exactly one on every clock edge, whatever the phase inputs do.
- R3: In mode 01 (double rate on A), every rising or falling edge of A is one step. The step is up when the new A level differs from the B level, and down otherwise. Edges of B alone cause no step.
- R4: In mode 10 (double rate on B), every edge of B is one step. The step is up when the new B level equals the A level, and down otherwise. Edges of A alone cause no step.
- R5: In mode 11 (quadruple rate), every edge of A or of B is one step, with the direction rule of R3 for A edges and of R4 for B edges. The A-leads-B sequence 00,10,11,01 (A,B) therefore counts up.
- R6: The direction output becomes 1 after a downward step and 0 after an upward step, and keeps its value while no step occurs.
- R7: An up step from a count at or above the ceiling gives 0. A down step from 0 gives the ceiling.
- R8: A ceiling write takes effect on the next clock edge and governs the very next step. A ceiling value greater than MAX_CEIL is ignored, and the old ceiling remains.
- R9: A count write is accepted only if the value does not exceed the ceiling in force before that edge. A rejected write leaves the count unchanged. No step is taken in a cycle that carries a count write.
- R10: A mode write only changes the staged mode. The active mode takes the staged value on the update strobe, with no step in that cycle and the enable bit untouched.
- R11: While enable is 0 the count holds its value in every mode.
- R12: A phase change made between clock edges shows up on the count output after the third following rising clock edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| mode_wr | input | 1 | Write strobe for the staged mode |
| mode_val | input | 2 | Mode to stage: 00 clock, 01 x2 on A, 10 x2 on B, 11 x4 |
| upd_stb | input | 1 | Update strobe: staged mode becomes active |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_val | input | 1 | Enable value to write |
| ceil_wr | input | 1 | Write strobe for the ceiling |
| ceil_val | input | CNT_W | Ceiling value to write |
| cnt_wr | input | 1 | Write strobe for the count |
| cnt_val | input | CNT_W | Count value to write |
| cnt_q | output | CNT_W | Current count |
| dir_q | output | 1 | 1 when the last step was downward |
| en_q | output | 1 | Current enable bit |
| mode_q | output | 2 | Active mode |
| ceil_q | output | CNT_W | Current ceiling |

## Verification
Each write strobe (mode update, enable, ceiling, count) is reflected on the outputs after exactly one rising edge. The bench drives every strobe on a falling edge, releases it on the next falling edge and reads the result there. A phase change needs three rising edges: two synchroniser stages and the count register. One dedicated test checks that the count is still unchanged after the first and second edges and has moved after the third. All other phase-driven tests wait four falling edges before they compare. In clock mode the count moves on every edge while enabled, so the expected value is the number of edges counted since enable went high.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    MODE_CLK = 2'b00,
    MODE_X2A = 2'b01,
    MODE_X2B = 2'b10,
    MODE_X4  = 2'b11
  } qenc_mode_e;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int CH     = 2,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] d,
  output logic [CH-1:0] q
);
  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= '0;
      else     sr <= {sr[STAGES-2:0], d[c]};
    end
    assign q[c] = sr[STAGES-1];
  end
endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder
  import qenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       a_s,
  input  logic       b_s,
  input  qenc_mode_e mode,
  output logic       step,
  output logic       up
);
  logic a_d, b_d;
  logic a_edge, b_edge;
  logic a_up, b_up;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_d <= 1'b0;
      b_d <= 1'b0;
    end else begin
      a_d <= a_s;
      b_d <= b_s;
    end
  end

  assign a_edge = a_s ^ a_d;
  assign b_edge = b_s ^ b_d;
  assign a_up   = a_s ^ b_s;
  assign b_up   = ~(a_s ^ b_s);

  always_comb begin
    step = 1'b0;
    up   = 1'b1;
    unique case (mode)
      MODE_CLK: begin
        step = 1'b1;
        up   = 1'b1;
      end
      MODE_X2A: begin
        step = a_edge;
        up   = a_up;
      end
      MODE_X2B: begin
        step = b_edge;
        up   = b_up;
      end
      MODE_X4: begin
        step = a_edge ^ b_edge;
        up   = a_edge ? a_up : b_up;
      end
      default: begin
        step = 1'b0;
        up   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/qenc_core.sv
module qenc_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_req,
  input  logic             step_up,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] ceil,
  output logic [CNT_W-1:0] cnt,
  output logic             dir
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      dir <= 1'b0;
    end else if (wr) begin
      if (wr_val <= ceil) cnt <= wr_val;
    end else if (step_req) begin
      dir <= ~step_up;
      if (step_up) cnt <= (cnt >= ceil) ? '0 : cnt + ONE;
      else         cnt <= (cnt == '0) ? ceil : cnt - ONE;
    end
  end
endmodule

// File: rtl/quad_enc_counter.sv
module quad_enc_counter
  import qenc_pkg::*;
#(
  parameter int               CNT_W    = 16,
  parameter logic [CNT_W-1:0] MAX_CEIL = '1,
  parameter int               SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             mode_wr,
  input  logic [1:0]       mode_val,
  input  logic             upd_stb,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic             ceil_wr,
  input  logic [CNT_W-1:0] ceil_val,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             dir_q,
  output logic             en_q,
  output logic [1:0]       mode_q,
  output logic [CNT_W-1:0] ceil_q
);
  qenc_mode_e       pend_mode;
  qenc_mode_e       act_mode;
  logic             en_r;
  logic [CNT_W-1:0] ceil_r;
  logic [1:0]       ph_s;
  logic             dec_step, dec_up;
  logic             step_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_mode <= MODE_CLK;
      act_mode  <= MODE_CLK;
      en_r      <= 1'b0;
      ceil_r    <= MAX_CEIL;
    end else begin
      if (mode_wr) pend_mode <= qenc_mode_e'(mode_val);
      if (upd_stb) act_mode  <= pend_mode;
      if (en_wr)   en_r      <= en_val;
      if (ceil_wr && (ceil_val <= MAX_CEIL)) ceil_r <= ceil_val;
    end
  end

  qenc_sync #(.CH(2), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({phase_b, phase_a}),
    .q   (ph_s)
  );

  qenc_decoder u_dec (
    .clk  (clk),
    .rst  (rst),
    .a_s  (ph_s[0]),
    .b_s  (ph_s[1]),
    .mode (act_mode),
    .step (dec_step),
    .up   (dec_up)
  );

  assign step_req = dec_step & en_r & ~upd_stb & ~cnt_wr;

  qenc_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .step_req (step_req),
    .step_up  (dec_up),
    .wr       (cnt_wr),
    .wr_val   (cnt_val),
    .ceil     (ceil_r),
    .cnt      (cnt_q),
    .dir      (dir_q)
  );

  assign en_q   = en_r;
  assign mode_q = act_mode;
  assign ceil_q = ceil_r;
endmodule

// File: rtl/qenc_checker.sv
module qenc_checker #(
  parameter int               CNT_W    = 16,
  parameter logic [CNT_W-1:0] MAX_CEIL = '1
) (
  input logic             clk,
  input logic             rst,
  input logic             en_q,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] cnt_q,
  input logic             dir_q,
  input logic [CNT_W-1:0] ceil_q,
  input logic             ceil_wr,
  input logic [CNT_W-1:0] ceil_val,
  input logic             upd_stb,
  input logic [1:0]       mode_q,
  input logic [1:0]       pend_mode,
  input logic             step_req,
  input logic             step_up
);
  assert_hold_disabled_R11: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !cnt_wr) |=> $stable(cnt_q));

  assert_write_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && cnt_val <= ceil_q) |=> (cnt_q == $past(cnt_val)));

  assert_write_reject_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && cnt_val > ceil_q) |=> $stable(cnt_q));

  assert_wrap_up_R7: assert property (@(posedge clk) disable iff (rst)
    (step_req && step_up && cnt_q >= ceil_q) |=> (cnt_q == '0));

  assert_wrap_down_R7: assert property (@(posedge clk) disable iff (rst)
    (step_req && !step_up && cnt_q == '0) |=> (cnt_q == $past(ceil_q)));

  assert_dir_R6: assert property (@(posedge clk) disable iff (rst)
    step_req |=> (dir_q == !$past(step_up)));

  assert_dir_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!step_req) |=> $stable(dir_q));

  assert_update_R10: assert property (@(posedge clk) disable iff (rst)
    upd_stb |=> (mode_q == $past(pend_mode)));

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!upd_stb) |=> $stable(mode_q));

  assert_no_step_on_update_R10: assert property (@(posedge clk) disable iff (rst)
    (upd_stb && !cnt_wr) |=> $stable(cnt_q));

  assert_ceil_limit_R8: assert property (@(posedge clk) disable iff (rst)
    (ceil_wr && ceil_val > MAX_CEIL) |=> $stable(ceil_q));
endmodule

bind quad_enc_counter qenc_checker #(.CNT_W(CNT_W), .MAX_CEIL(MAX_CEIL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_q      (en_q),
  .cnt_wr    (cnt_wr),
  .cnt_val   (cnt_val),
  .cnt_q     (cnt_q),
  .dir_q     (dir_q),
  .ceil_q    (ceil_q),
  .ceil_wr   (ceil_wr),
  .ceil_val  (ceil_val),
  .upd_stb   (upd_stb),
  .mode_q    (mode_q),
  .pend_mode (pend_mode),
  .step_req  (step_req),
  .step_up   (dec_up)
);

// File: tb/quad_enc_counter_tb.sv
module quad_enc_counter_tb;
  localparam int               W    = 16;
  localparam logic [W-1:0]     MAXC = 16'd1000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         phase_a = 1'b0, phase_b = 1'b0;
  logic         mode_wr = 1'b0, upd_stb = 1'b0, en_wr = 1'b0, en_val = 1'b0;
  logic         ceil_wr = 1'b0, cnt_wr = 1'b0;
  logic [1:0]   mode_val = 2'b00;
  logic [W-1:0] ceil_val = '0, cnt_val = '0;
  logic [W-1:0] cnt_q, ceil_q;
  logic         dir_q, en_q;
  logic [1:0]   mode_q;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int exp_cnt = 0, ceil_m = 1000, mode_m = 0, idx = 0;
  bit en_m = 0;

  always #4 clk = ~clk;

  quad_enc_counter #(.CNT_W(W), .MAX_CEIL(MAXC)) u_dut (
    .clk(clk), .rst(rst), .phase_a(phase_a), .phase_b(phase_b),
    .mode_wr(mode_wr), .mode_val(mode_val), .upd_stb(upd_stb),
    .en_wr(en_wr), .en_val(en_val), .ceil_wr(ceil_wr), .ceil_val(ceil_val),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val), .cnt_q(cnt_q), .dir_q(dir_q),
    .en_q(en_q), .mode_q(mode_q), .ceil_q(ceil_q)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step(input bit upm);
    if (upm) exp_cnt = (exp_cnt >= ceil_m) ? 0 : exp_cnt + 1;
    else     exp_cnt = (exp_cnt == 0) ? ceil_m : exp_cnt - 1;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk); en_wr = 1'b1; en_val = v;
    @(negedge clk); en_wr = 1'b0;
    en_m = v;
  endtask

  task automatic wr_cnt(input int v);
    @(negedge clk); cnt_wr = 1'b1; cnt_val = W'(v);
    @(negedge clk); cnt_wr = 1'b0;
    if (v <= ceil_m) exp_cnt = v;
  endtask

  task automatic wr_ceil(input int v);
    @(negedge clk); ceil_wr = 1'b1; ceil_val = W'(v);
    @(negedge clk); ceil_wr = 1'b0;
    if (v <= int'(MAXC)) ceil_m = v;
  endtask

  task automatic cfg_mode(input int m, input string req);
    @(negedge clk); mode_wr = 1'b1; mode_val = 2'(m);
    @(negedge clk); mode_wr = 1'b0; upd_stb = 1'b1;
    @(negedge clk); upd_stb = 1'b0;
    mode_m = m;
    chk(req, "active mode", 32'(mode_q), 32'(m));
  endtask

  // drive a new phase pair, predict the step from the requirement rules
  task automatic drive_ab(input logic na, input logic nb, input string req);
    logic ac, bc, cnts, upm;
    ac = (na != phase_a); bc = (nb != phase_b);
    cnts = 1'b0; upm = 1'b1;
    case (mode_m)
      1: begin cnts = ac; upm = na ^ nb; end
      2: begin cnts = bc; upm = ~(na ^ nb); end
      3: begin cnts = ac ^ bc; upm = ac ? (na ^ nb) : ~(na ^ nb); end
      default: cnts = 1'b0;
    endcase
    @(negedge clk); phase_a = na; phase_b = nb;
    repeat (4) @(negedge clk);
    if (cnts && en_m) model_step(upm);
    chk(req, "count", 32'(cnt_q), 32'(exp_cnt));
    if (cnts && en_m) chk(req, "direction", 32'(dir_q), 32'(!upm));
  endtask

  task automatic move(input bit fwd, input string req);
    int ni;
    ni = fwd ? (idx + 1) % 4 : (idx + 3) % 4;
    idx = ni;
    drive_ab(ni == 1 || ni == 2, ni == 2 || ni == 3, req);
  endtask

  task automatic t_reset;
    chk("R1", "count", 32'(cnt_q), 0);
    chk("R1", "direction", 32'(dir_q), 0);
    chk("R1", "enable", 32'(en_q), 0);
    chk("R1", "mode", 32'(mode_q), 0);
    chk("R1", "ceiling", 32'(ceil_q), 32'(MAXC));
  endtask

  task automatic t_clock_mode;
    wr_cnt(0);
    @(negedge clk); en_wr = 1'b1; en_val = 1'b1;
    @(negedge clk); en_wr = 1'b0;
    chk("R2", "count at enable", 32'(cnt_q), 0);
    repeat (5) begin @(negedge clk); phase_a = ~phase_a; phase_b = ~phase_a; end
    chk("R2", "count after 5 edges", 32'(cnt_q), 5);
    en_wr = 1'b1; en_val = 1'b0;
    @(negedge clk); en_wr = 1'b0;
    chk("R2", "count on disabling edge", 32'(cnt_q), 6);
    repeat (5) @(negedge clk);
    chk("R11", "count held while disabled", 32'(cnt_q), 6);
    chk("R11", "enable", 32'(en_q), 0);
    phase_a = 1'b0; phase_b = 1'b0; idx = 0;
    repeat (4) @(negedge clk);
    chk("R11", "count held after phase moves", 32'(cnt_q), 6);
    exp_cnt = 6; en_m = 0;
  endtask

  task automatic t_x2a;
    cfg_mode(1, "R10");
    wr_cnt(10); set_en(1'b1);
    for (int i = 0; i < 4; i++) move(1'b1, "R3");
    chk("R3", "two steps up", 32'(cnt_q), 12);
    for (int i = 0; i < 4; i++) move(1'b0, "R3");
    chk("R3", "back to start", 32'(cnt_q), 10);
    drive_ab(1'b0, 1'b1, "R3");
    drive_ab(1'b0, 1'b0, "R3");
    chk("R3", "B edges ignored", 32'(cnt_q), 10);
  endtask

  task automatic t_staged;
    // still in mode 01 and enabled; stage mode 11 without update
    @(negedge clk); mode_wr = 1'b1; mode_val = 2'b11;
    @(negedge clk); mode_wr = 1'b0;
    chk("R10", "active mode unchanged", 32'(mode_q), 1);
    drive_ab(1'b0, 1'b1, "R10");
    drive_ab(1'b0, 1'b0, "R10");
    chk("R10", "staged mode not in effect", 32'(cnt_q), 10);
    @(negedge clk); upd_stb = 1'b1;
    @(negedge clk); upd_stb = 1'b0;
    mode_m = 3;
    chk("R10", "mode after strobe", 32'(mode_q), 3);
    chk("R10", "enable kept", 32'(en_q), 1);
  endtask

  task automatic t_x2b;
    set_en(1'b0);
    cfg_mode(2, "R10");
    wr_cnt(20); set_en(1'b1);
    for (int i = 0; i < 4; i++) move(1'b1, "R4");
    chk("R4", "two steps up", 32'(cnt_q), 22);
    for (int i = 0; i < 8; i++) move(1'b0, "R4");
    chk("R4", "four steps down", 32'(cnt_q), 18);
    chk("R6", "direction after down", 32'(dir_q), 1);
    drive_ab(1'b1, 1'b0, "R4");
    drive_ab(1'b0, 1'b0, "R4");
    chk("R4", "A edges ignored", 32'(cnt_q), 18);
    chk("R6", "direction held", 32'(dir_q), 1);
  endtask

  task automatic t_x4_latency;
    set_en(1'b0);
    cfg_mode(3, "R10");
    wr_cnt(100); set_en(1'b1);
    @(negedge clk); phase_a = 1'b1; idx = 1;
    @(negedge clk);
    chk("R12", "after edge 1", 32'(cnt_q), 100);
    @(negedge clk);
    chk("R12", "after edge 2", 32'(cnt_q), 100);
    @(negedge clk);
    chk("R12", "after edge 3", 32'(cnt_q), 101);
    exp_cnt = 101;
    for (int i = 0; i < 3; i++) move(1'b1, "R5");
    chk("R5", "full cycle up", 32'(cnt_q), 104);
    chk("R6", "direction after up", 32'(dir_q), 0);
    for (int i = 0; i < 2; i++) move(1'b0, "R5");
    chk("R5", "two down", 32'(cnt_q), 102);
  endtask

  task automatic t_wrap;
    wr_ceil(9);
    chk("R8", "ceiling written", 32'(ceil_q), 9);
    wr_cnt(4);
    wr_ceil(4);
    move(1'b1, "R8");
    chk("R8", "new ceiling governs next step", 32'(cnt_q), 0);
    wr_ceil(5);
    wr_cnt(4);
    move(1'b1, "R7");
    move(1'b1, "R7");
    chk("R7", "wrap up to 0", 32'(cnt_q), 0);
    move(1'b0, "R7");
    chk("R7", "wrap down to ceiling", 32'(cnt_q), 5);
    wr_ceil(int'(MAXC) + 1);
    chk("R8", "oversize ceiling ignored", 32'(ceil_q), 5);
  endtask

  task automatic t_cnt_write;
    wr_cnt(6);
    chk("R9", "write above ceiling rejected", 32'(cnt_q), 5);
    wr_cnt(2);
    chk("R9", "write accepted", 32'(cnt_q), 2);
    wr_cnt(5);
    chk("R9", "write at ceiling accepted", 32'(cnt_q), 5);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clock_mode();
    t_x2a();
    t_staged();
    t_x2b();
    t_x4_latency();
    t_wrap();
    t_cnt_write();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule